// File: doc/BRIEF.md
# Programmable Multi-Line Video Delay Bank

This block holds the recent rows of a video stream so that a two-dimensional filter window can see several vertically aligned pixels at once. Every pixel clock it accepts one 8-bit pixel and presents one pixel from each delayed row on its own tap. Each tap lags the tap above it by exactly one programmed line length.

A fixed pool of 4096 pixel locations (32 kbit) is shared by all rows. It can be split two ways: four rows of up to 1024 pixels each, or eight rows of up to 512 pixels each. The rows form two equal groups. In chained operation the last row of the first group feeds the first row of the second group, giving one deep stack of taps. In split operation the second group takes its pixels from a second input port, so one stack can hold the current field and the other an earlier field or frame. An optional fixed delay can be inserted in front of both groups.

The configuration inputs are expected to hold steady between resets. All rows share one circular position counter. Every tap is a registered output.

Top module: `line_delay_bank`

## Requirements
- R1: While reset is high, and afterwards until the stored data for a tap is real, each tap reads 0. Tap j carries no earlier input than the first pixel accepted after reset.
- R2: With `cfg_short`=0 (four rows) and `cfg_split`=0, tap j (j=0..3) in the cycle after clock edge e carries the primary pixel sampled at edge e-(j+1)*L, where L is the effective line length.
- R3: With `cfg_short`=1 (eight rows) and `cfg_split`=0, tap j (j=0..7) follows the same rule as R2 across all eight rows.
- R4: `cfg_len` holds the line length minus one. A value of 0 is treated as a length of 2. With `cfg_short`=1, any length above 512 is limited to 512. With `cfg_short`=0, lengths up to 1024 are used as given.
- R5: With `cfg_split`=1, the second group (taps G..2G-1, where G=2 for four rows and G=4 for eight rows) is fed from `pix_b`. Tap G+k carries `pix_b` from edge e-(k+1)*L. The first group still follows `pix_a` only.
- R6: With `cfg_split`=0, `pix_b` has no effect on any tap. The second group continues the chain from the first.
- R7: With `cfg_pre`=1, every tap is delayed by PRE_DLY (default 4) extra clocks on top of R2, R3 and R5. With `cfg_pre`=0, no extra delay is added.
- R8: With `cfg_short`=0, taps 4..7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_short | input | 1 | 0: four long rows, 1: eight short rows |
| cfg_split | input | 1 | 0: groups chained, 1: second group fed from pix_b |
| cfg_pre | input | 1 | 1: insert PRE_DLY clocks ahead of the row stores |
| cfg_len | input | 10 | Line length minus one |
| pix_a | input | 8 | Primary pixel input |
| pix_b | input | 8 | Second-group pixel input (split operation) |
| taps | output | 64 | Tap j on bits [8j+7:8j] |

## Verification
The bench drives random pixels on both inputs and predicts every tap in every cycle from a history of what it drove. The corner cases it targets are these:
- The shortest line. A design that read and wrote the same location would show a lag of L+1 instead of L.
- The 512-pixel limit in eight-row mode. A missing limit would make the pointer run into the neighbouring row's store.
- The group boundary in both organisations. A wrong boundary would draw the second group from the wrong source, or let `pix_b` leak into a chained stack.
- The fill window after reset. A design that gated too early would expose stale store contents, and one that gated too late would hide the first pixels.

// File: rtl/ldb_pkg.sv
`timescale 1ns/1ps
package ldb_pkg;
  typedef enum logic {ORG_LONG = 1'b0, ORG_SHORT = 1'b1} ldb_org_e;
  typedef enum logic {FEED_CHAIN = 1'b0, FEED_SPLIT = 1'b1} ldb_feed_e;
endpackage

// File: rtl/ldb_bank.sv
`timescale 1ns/1ps
// One row store: write port and read port on separate addresses,
// registered read so that a block RAM can be inferred.
module ldb_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ldb_ptr.sv
`timescale 1ns/1ps
// Shared circular position: write address, read-ahead address, fill flag.
module ldb_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lenm1,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          live
);
  // the read side looks one slot ahead: that slot was written L-1 edges ago
  always_comb rptr = (wptr >= lenm1) ? '0 : wptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      live <= 1'b0;
    end else begin
      wptr <= rptr;
      if (wptr >= lenm1) live <= 1'b1;
    end
  end

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (wptr == lenm1) |=> (wptr == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (wptr < lenm1) |=> (wptr == $past(wptr) + 1'b1));
  p_live_hold_r1: assert property (@(posedge clk) disable iff (rst)
    live |=> live);
  p_live_wait_r1: assert property (@(posedge clk) disable iff (rst)
    (!live && (wptr < lenm1)) |=> !live);
endmodule

// File: rtl/ldb_predly.sv
`timescale 1ns/1ps
// Optional fixed delay ahead of the row stores.
module ldb_predly #(
  parameter int DW  = 8,
  parameter int DLY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stg [DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DLY; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < DLY; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = en ? stg[DLY-1] : din;

  p_stage_in_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stg[0] == $past(din)));

  for (genvar k = 1; k < DLY; k++) begin : g_chk
    p_stage_shift_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (stg[k] == $past(stg[k-1])));
  end
endmodule

// File: rtl/line_delay_bank.sv
`timescale 1ns/1ps
module line_delay_bank
  import ldb_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LINES_MAX = 8,
  parameter int LONG_LEN  = 1024,
  parameter int PRE_DLY   = 4,
  parameter int AW        = $clog2(LONG_LEN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_short,
  input  logic                       cfg_split,
  input  logic                       cfg_pre,
  input  logic [AW-1:0]              cfg_len,
  input  logic [PIX_W-1:0]           pix_a,
  input  logic [PIX_W-1:0]           pix_b,
  output logic [LINES_MAX*PIX_W-1:0] taps
);
  localparam int SHORT_LEN = LONG_LEN / 2;
  localparam int BAW       = AW - 1;
  localparam int GRP_S     = LINES_MAX / 2;
  localparam int GRP_L     = LINES_MAX / 4;

  ldb_org_e  org;
  ldb_feed_e feed;
  assign org  = ldb_org_e'(cfg_short);
  assign feed = ldb_feed_e'(cfg_split);

  // effective length minus one: at least 1, capped in eight-row mode
  logic [AW-1:0] lenm1;
  always_comb begin
    lenm1 = cfg_len;
    if (org == ORG_SHORT && cfg_len > AW'(SHORT_LEN - 1)) lenm1 = AW'(SHORT_LEN - 1);
    if (lenm1 == '0) lenm1 = AW'(1);
  end

  logic [AW-1:0] wptr, rptr;
  logic          live;
  ldb_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .lenm1(lenm1),
    .wptr(wptr), .rptr(rptr), .live(live)
  );

  logic [PIX_W-1:0] a_in, b_in;
  ldb_predly #(.DW(PIX_W), .DLY(PRE_DLY)) u_pre_a (
    .clk(clk), .rst(rst), .en(cfg_pre), .din(pix_a), .dout(a_in));
  ldb_predly #(.DW(PIX_W), .DLY(PRE_DLY)) u_pre_b (
    .clk(clk), .rst(rst), .en(cfg_pre), .din(pix_b), .dout(b_in));

  // bank half selected by the read address, aligned with the read data
  logic rsel;
  always_ff @(posedge clk) begin
    if (rst) rsel <= 1'b0;
    else     rsel <= rptr[AW-1];
  end

  logic [PIX_W-1:0] rd      [LINES_MAX];
  logic [PIX_W-1:0] raw     [LINES_MAX];
  logic [PIX_W-1:0] tap_g   [LINES_MAX];
  logic [PIX_W-1:0] line_in [LINES_MAX];

  // physical stores: one per short row, a pair per long row
  for (genvar b = 0; b < LINES_MAX; b++) begin : g_bank
    logic             we;
    logic [PIX_W-1:0] wd;
    assign we = (org == ORG_SHORT) || (wptr[AW-1] == 1'(b % 2));
    assign wd = (org == ORG_SHORT) ? line_in[b] : line_in[b/2];
    ldb_bank #(.DW(PIX_W), .DEPTH(SHORT_LEN)) u_bank (
      .clk(clk), .we(we), .waddr(wptr[BAW-1:0]), .wdata(wd),
      .raddr(rptr[BAW-1:0]), .rdata(rd[b])
    );
  end

  // logical rows: read side, fill gating, and feed into the next row
  for (genvar j = 0; j < LINES_MAX; j++) begin : g_row
    if (j < LINES_MAX / 2) begin : g_dual
      assign raw[j] = (org == ORG_SHORT) ? rd[j] : (rsel ? rd[2*j+1] : rd[2*j]);
    end else begin : g_single
      assign raw[j] = (org == ORG_SHORT) ? rd[j] : '0;
    end
    assign tap_g[j] = live ? raw[j] : '0;

    if (j == 0) begin : g_head
      assign line_in[j] = a_in;
    end else begin : g_link
      logic grp_b_head;
      assign grp_b_head = (feed == FEED_SPLIT) &&
                          ((org == ORG_SHORT) ? (j == GRP_S) : (j == GRP_L));
      assign line_in[j] = grp_b_head ? b_in : tap_g[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) taps <= '0;
    else for (int j = 0; j < LINES_MAX; j++) taps[j*PIX_W +: PIX_W] <= tap_g[j];
  end

  p_len_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (org == ORG_SHORT) |-> (lenm1 <= AW'(SHORT_LEN - 1)) && (lenm1 != '0));
  p_upper_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (org == ORG_LONG) |=> (taps[LINES_MAX*PIX_W-1:GRP_S*PIX_W] == '0));
endmodule

// File: tb/test_line_delay_bank.sv
`timescale 1ns/1ps
module test_line_delay_bank;
  localparam int PW = 8;
  localparam int NL = 8;
  localparam int PD = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_short = 1'b0, cfg_split = 1'b0, cfg_pre = 1'b0;
  logic [9:0]    cfg_len = '0;
  logic [PW-1:0] pix_a = '0, pix_b = '0;
  logic [NL*PW-1:0] taps;

  always #2.5 clk = ~clk;

  line_delay_bank i_line_delay_bank (
    .clk(clk), .rst(rst), .cfg_short(cfg_short), .cfg_split(cfg_split),
    .cfg_pre(cfg_pre), .cfg_len(cfg_len), .pix_a(pix_a), .pix_b(pix_b),
    .taps(taps)
  );

  logic [PW-1:0] ha[$];
  logic [PW-1:0] hb[$];
  int    eff_len, dly, ecnt, n_chk, n_fail;
  bit    mon_on, done;
  string run_tag;

  task automatic check(string req, int lane, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s tap %0d edge %0d: actual=%0h expected=%0h", req, lane, ecnt, act, exp);
    end
  endtask

  // monitor: predicts each tap from the history the driver recorded
  always @(posedge clk) begin
    if (mon_on) begin
      int lines, g, k, idx;
      bit fromb;
      logic [PW-1:0] e;
      string req;
      #1;
      lines = cfg_short ? 8 : 4;
      g = lines / 2;
      for (int j = 0; j < NL; j++) begin
        if (j >= lines) begin
          e = '0; req = "R8";
        end else begin
          fromb = cfg_split && (j >= g);
          k = fromb ? j - g : j;
          idx = ecnt - (k + 1) * eff_len - dly;
          if (idx < 0) begin
            e = '0; req = "R1";
          end else begin
            e = fromb ? hb[idx] : ha[idx];
            req = fromb ? "R5" : ((j >= g) ? "R6" : run_tag);
          end
        end
        check(req, j, taps[j*PW +: PW], e);
      end
      ecnt++;
    end
  end

  // driver: configures, resets, then pushes every driven pixel to history
  task automatic run(string tag, bit s, bit sp, bit pre, int len, int cycles);
    int l;
    @(negedge clk);
    rst = 1'b1; mon_on = 1'b0;
    cfg_short = s; cfg_split = sp; cfg_pre = pre; cfg_len = 10'(len);
    ha.delete(); hb.delete();
    l = len + 1;
    if (l < 2) l = 2;                 // R4 minimum
    if (s && l > 512) l = 512;        // R4 cap in eight-row mode
    eff_len = l;
    dly = pre ? PD : 0;               // R7
    run_tag = tag;
    repeat (3) @(negedge clk);
    for (int j = 0; j < NL; j++) check("R1", j, taps[j*PW +: PW], '0);
    rst = 1'b0; ecnt = 0; mon_on = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      pix_a = PW'($urandom);
      pix_b = PW'($urandom);
      ha.push_back(pix_a);
      hb.push_back(pix_b);
      @(negedge clk);
    end
    mon_on = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; mon_on = 1'b0;
    run("R2", 1'b0, 1'b0, 1'b0, 4,    60);    // four rows, chained, L=5
    run("R7", 1'b1, 1'b0, 1'b1, 6,    100);   // eight rows, pre-delay, L=7
    run("R3", 1'b1, 1'b1, 1'b0, 2,    50);    // eight rows, split, L=3
    run("R4", 1'b0, 1'b1, 1'b1, 0,    40);    // four rows, split, minimum length
    run("R4", 1'b1, 1'b0, 1'b0, 1023, 4200);  // eight rows, length capped at 512
    run("R2", 1'b0, 1'b0, 1'b0, 1023, 4200);  // four rows, full 1024
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule